// File: doc/BRIEF.md
# UDP/IPv4 Frame Transmit Sequencer

The sequencer produces a complete Ethernet II frame that carries one UDP datagram over IPv4. It streams the frame one byte per clock to a MAC client transmit port. The port uses three active-high flags: a byte-valid flag, a first-byte flag and a last-byte flag. A frame begins with a one-cycle start pulse. On that pulse the 16-bit payload byte count is sampled. The block then sends a fixed 42-byte header followed by the payload.

Most header bytes are constants. The addresses and ports are set by parameters. The IPv4 total length and the UDP length are computed from the sampled count at run time. The IPv4 header checksum is not summed over the whole header. It is patched from a configured base value, which is the checksum of the same header with an empty payload. The payload is pulled from the user through a phase output. The phase output rises one cycle before the block needs the first payload byte.

The block shares a single clock and a synchronous active-high reset with the downstream port. It has no flow control from the downstream side.

Top module: `udp_frame_tx`

## Requirements
- R1: When the block is idle, a high `start_i` samples `pay_len_i`. At the next clock edge, frame byte 0 is presented with `sof_o` and `src_rdy_o` high. The value of `pay_len_i` in any other cycle has no effect.
- R2: Header bytes are sent in fixed order, each multi-byte field most significant byte first:
  - bytes 0-5 carry the destination MAC and bytes 6-11 the source MAC;
  - bytes 12-13 carry 0x0800;
  - bytes 14-23 carry 0x45, 0x00, the length, 0x00, 0x00, 0x40, 0x00, 0x40 and 0x11;
  - bytes 26-29 carry the source IP and bytes 30-33 the destination IP;
  - bytes 34-35 carry the source port and bytes 36-37 the destination port;
  - bytes 40-41 carry 0x00 0x00.
- R3: Bytes 16-17 carry 28 plus the payload length. Bytes 38-39 carry 8 plus the payload length. Both are sent most significant byte first.
- R4: Bytes 24-25 carry the IPv4 header checksum, most significant byte first. The value is the ones'-complement of the ones'-complement sum of `~CSUM_BASE` and the payload length. It equals the checksum computed over the full 20-byte header.
- R5: `src_rdy_o` is high on every byte of a frame, which is 42 plus the payload length bytes in consecutive cycles. It is low in the cycle after the last byte.
- R6: `sof_o` is high only with byte 0. `eof_o` is high only with the last byte of the frame.
- R7: With a non-zero length N, `pay_phase_o` rises in the cycle that byte 40 is on `data_o` and stays high for N+1 cycles. The value on `pay_data_i` in the k-th cycle after the rise (k = 1..N) is sent as frame byte 41+k.
- R8: With a payload length of zero, only the 42 header bytes are sent, `eof_o` is high with byte 41, and `pay_phase_o` never rises.
- R9: A start pulse while a frame is in progress is ignored. It starts no new frame and does not alter the frame in progress.
- R10: While `rst` is high at a clock edge, the block returns to idle with `src_rdy_o`, `sof_o`, `eof_o` and `pay_phase_o` low. This holds even in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared with the downstream port |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle frame start request |
| pay_len_i | input | 16 | Payload length in bytes, sampled with the start pulse |
| pay_data_i | input | 8 | Payload byte supplied by the user |
| pay_phase_o | output | 1 | High while payload bytes are being fetched |
| data_o | output | 8 | Frame byte |
| sof_o | output | 1 | First byte of frame |
| eof_o | output | 1 | Last byte of frame |
| src_rdy_o | output | 1 | `data_o` holds a valid frame byte |

## Verification
Frames are sent with payload lengths of zero, one, two, a small odd count, 64, 300 and 1400. Each pattern gives different carries in the length fields and in the checksum patch, so the checksum bytes are compared against a checksum the bench sums over the full header. The zero-length frame separates a header-only frame from a one-byte payload, which is the case where the phase output and the last-byte flag are most likely to be off by one. Back-to-back frames, a second start pulse in mid-frame, and a reset during the header each test whether frame boundaries stay intact. The payload bytes follow a pattern keyed to each frame's position, so a payload slipped by one cycle is reported.

// File: rtl/udp_frame_pkg.sv
package udp_frame_pkg;

    localparam int HDR_BYTES = 42;
    localparam int IDX_W     = $clog2(HDR_BYTES);
    localparam int LEN_W     = 16;
    localparam int IP_OVH    = 28;
    localparam int UDP_OVH   = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_PAY  = 2'd2
    } tx_state_e;

    typedef struct packed {
        tx_state_e        st;
        logic [IDX_W-1:0] hidx;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] rem;
        logic [7:0]       data;
        logic             sof;
        logic             eof;
        logic             vld;
        logic             phase;
    } tx_regs_t;

    // Checksum of the IPv4 header for an empty payload, used as the default base.
    function automatic logic [15:0] empty_hdr_csum(input logic [31:0] sip, input logic [31:0] dip);
        logic [31:0] acc;
        acc = 32'h4500 + 32'(IP_OVH) + 32'h4000 + 32'h4011
            + {16'h0, sip[31:16]} + {16'h0, sip[15:0]}
            + {16'h0, dip[31:16]} + {16'h0, dip[15:0]};
        acc = {16'h0, acc[15:0]} + {16'h0, acc[31:16]};
        acc = {16'h0, acc[15:0]} + {16'h0, acc[31:16]};
        return ~acc[15:0];
    endfunction

endpackage

// File: rtl/udp_len_fields.sv
module udp_len_fields
    import udp_frame_pkg::*;
#(
    parameter logic [15:0] CSUM_BASE = 16'h0000
) (
    input  logic [LEN_W-1:0] pay_len_i,
    output logic [15:0]      ip_len_o,
    output logic [15:0]      udp_len_o,
    output logic [15:0]      csum_o
);

    logic [16:0] raw_sum;
    logic [15:0] folded;

    assign ip_len_o  = pay_len_i + 16'(IP_OVH);
    assign udp_len_o = pay_len_i + 16'(UDP_OVH);

    // Incremental ones'-complement patch: undo the final inversion, add the
    // length delta with end-around carry, then invert again.
    assign raw_sum = {1'b0, ~CSUM_BASE} + {1'b0, pay_len_i};
    assign folded  = raw_sum[15:0] + {15'd0, raw_sum[16]};
    assign csum_o  = ~folded;

endmodule

// File: rtl/udp_hdr_bytes.sv
module udp_hdr_bytes
    import udp_frame_pkg::*;
#(
    parameter logic [47:0] DST_MAC  = 48'h0,
    parameter logic [47:0] SRC_MAC  = 48'h0,
    parameter logic [31:0] SRC_IP   = 32'h0,
    parameter logic [31:0] DST_IP   = 32'h0,
    parameter logic [15:0] SRC_PORT = 16'h0,
    parameter logic [15:0] DST_PORT = 16'h0
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic [15:0]      ip_len_i,
    input  logic [15:0]      udp_len_i,
    input  logic [15:0]      csum_i,
    output logic [7:0]       byte_o
);

    localparam int HDR_BITS   = 8 * HDR_BYTES;
    localparam int POS_IPLEN  = 16;
    localparam int POS_CSUM   = 24;
    localparam int POS_UDPLEN = 38;

    // Constant image of the header; run-time fields are zero here and
    // substituted below.
    localparam logic [HDR_BITS-1:0] HDR_IMG = {
        DST_MAC, SRC_MAC, 16'h0800,
        8'h45, 8'h00, 16'h0000, 16'h0000, 16'h4000, 8'h40, 8'h11, 16'h0000,
        SRC_IP, DST_IP,
        SRC_PORT, DST_PORT, 16'h0000, 16'h0000
    };

    logic [7:0] const_byte;

    always_comb begin
        const_byte = 8'h00;
        for (int i = 0; i < HDR_BYTES; i++) begin
            if (idx_i == IDX_W'(i)) begin
                const_byte = HDR_IMG[HDR_BITS-8-8*i +: 8];
            end
        end
    end

    always_comb begin
        case (idx_i)
            IDX_W'(POS_IPLEN):      byte_o = ip_len_i[15:8];
            IDX_W'(POS_IPLEN + 1):  byte_o = ip_len_i[7:0];
            IDX_W'(POS_CSUM):       byte_o = csum_i[15:8];
            IDX_W'(POS_CSUM + 1):   byte_o = csum_i[7:0];
            IDX_W'(POS_UDPLEN):     byte_o = udp_len_i[15:8];
            IDX_W'(POS_UDPLEN + 1): byte_o = udp_len_i[7:0];
            default:                byte_o = const_byte;
        endcase
    end

endmodule

// File: rtl/udp_frame_tx.sv
module udp_frame_tx
    import udp_frame_pkg::*;
#(
    parameter logic [47:0] DST_MAC   = 48'h0A1B_2C3D_4E5F,
    parameter logic [47:0] SRC_MAC   = 48'h0200_00C0_FFEE,
    parameter logic [31:0] SRC_IP    = 32'hC0A8_0A02,
    parameter logic [31:0] DST_IP    = 32'hC0A8_0A01,
    parameter logic [15:0] SRC_PORT  = 16'd5000,
    parameter logic [15:0] DST_PORT  = 16'd6000,
    parameter logic [15:0] CSUM_BASE = empty_hdr_csum(SRC_IP, DST_IP)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [LEN_W-1:0] pay_len_i,
    input  logic [7:0]       pay_data_i,
    output logic             pay_phase_o,
    output logic [7:0]       data_o,
    output logic             sof_o,
    output logic             eof_o,
    output logic             src_rdy_o
);

    localparam logic [IDX_W-1:0] LAST_HDR = IDX_W'(HDR_BYTES - 1);
    localparam logic [IDX_W-1:0] PHASE_AT = IDX_W'(HDR_BYTES - 2);
    localparam tx_regs_t REGS_RST = '{st: ST_IDLE, default: '0};

    tx_regs_t   r_q, r_d;
    logic [15:0] ip_len, udp_len, csum;
    logic [7:0]  hdr_byte;
    logic        busy_q;

    udp_len_fields #(
        .CSUM_BASE (CSUM_BASE)
    ) u_fields (
        .pay_len_i (r_q.len),
        .ip_len_o  (ip_len),
        .udp_len_o (udp_len),
        .csum_o    (csum)
    );

    udp_hdr_bytes #(
        .DST_MAC  (DST_MAC),
        .SRC_MAC  (SRC_MAC),
        .SRC_IP   (SRC_IP),
        .DST_IP   (DST_IP),
        .SRC_PORT (SRC_PORT),
        .DST_PORT (DST_PORT)
    ) u_hdr (
        .idx_i     (r_q.hidx),
        .ip_len_i  (ip_len),
        .udp_len_i (udp_len),
        .csum_i    (csum),
        .byte_o    (hdr_byte)
    );

    always_comb begin
        r_d     = r_q;
        r_d.sof = 1'b0;
        r_d.eof = 1'b0;
        r_d.vld = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    // hidx_q is zero in idle, so hdr_byte is byte 0
                    r_d.st   = ST_HDR;
                    r_d.len  = pay_len_i;
                    r_d.data = hdr_byte;
                    r_d.sof  = 1'b1;
                    r_d.vld  = 1'b1;
                    r_d.hidx = IDX_W'(1);
                end
            end
            ST_HDR: begin
                r_d.data = hdr_byte;
                r_d.vld  = 1'b1;
                r_d.hidx = r_q.hidx + IDX_W'(1);
                if (r_q.hidx == PHASE_AT && r_q.len != '0) begin
                    r_d.phase = 1'b1;
                end
                if (r_q.hidx == LAST_HDR) begin
                    r_d.hidx = '0;
                    if (r_q.len == '0) begin
                        r_d.eof = 1'b1;
                        r_d.st  = ST_IDLE;
                    end else begin
                        r_d.rem = r_q.len;
                        r_d.st  = ST_PAY;
                    end
                end
            end
            ST_PAY: begin
                r_d.data = pay_data_i;
                r_d.vld  = 1'b1;
                r_d.rem  = r_q.rem - LEN_W'(1);
                if (r_q.rem == LEN_W'(1)) begin
                    r_d.eof   = 1'b1;
                    r_d.phase = 1'b0;
                    r_d.st    = ST_IDLE;
                end
            end
            default: r_d = REGS_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_q      = (r_q.st != ST_IDLE);
    assign data_o      = r_q.data;
    assign sof_o       = r_q.sof;
    assign eof_o       = r_q.eof;
    assign src_rdy_o   = r_q.vld;
    assign pay_phase_o = r_q.phase;

endmodule

// File: rtl/udp_frame_tx_chk.sv
module udp_frame_tx_chk (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic busy,
    input logic sof_o,
    input logic eof_o,
    input logic src_rdy_o,
    input logic pay_phase_o
);

    a_r1_sof_follows_start: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy) |=> (sof_o && src_rdy_o));

    a_r6_sof_single: assert property (@(posedge clk) disable iff (rst)
        sof_o |=> !sof_o);

    a_r6_eof_on_valid: assert property (@(posedge clk) disable iff (rst)
        eof_o |-> (src_rdy_o && !sof_o));

    a_r5_gap_after_eof: assert property (@(posedge clk) disable iff (rst)
        eof_o |=> !src_rdy_o);

    a_r7_phase_in_frame: assert property (@(posedge clk) disable iff (rst)
        pay_phase_o |-> (src_rdy_o && !eof_o));

    a_r9_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (start_i && busy) |=> !sof_o);

    a_r10_reset_quiet: assert property (@(posedge clk)
        rst |=> (!src_rdy_o && !sof_o && !eof_o && !pay_phase_o));

endmodule

bind udp_frame_tx udp_frame_tx_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .busy        (busy_q),
    .sof_o       (sof_o),
    .eof_o       (eof_o),
    .src_rdy_o   (src_rdy_o),
    .pay_phase_o (pay_phase_o)
);

// File: tb/udp_frame_tx_bench.sv
`timescale 1ns/1ps
module udp_frame_tx_bench;

    localparam logic [47:0] B_DMAC  = 48'h6C_2B_59_11_22_33;
    localparam logic [47:0] B_SMAC  = 48'hFE_DC_BA_98_76_54;
    localparam logic [31:0] B_SIP   = 32'h0A_00_00_07;
    localparam logic [31:0] B_DIP   = 32'hAC_10_FF_FE;
    localparam logic [15:0] B_SPORT = 16'hBEEF;
    localparam logic [15:0] B_DPORT = 16'h0FA1;

    function automatic logic [15:0] full_csum(input int len);
        logic [31:0] s;
        s = 32'h4500 + 32'(28 + len) + 32'h0000 + 32'h4000 + 32'h4011 + 32'h0000
          + B_SIP[31:16] + B_SIP[15:0] + B_DIP[31:16] + B_DIP[15:0];
        while (s[31:16] != 0) s = {16'h0, s[15:0]} + {16'h0, s[31:16]};
        return ~s[15:0];
    endfunction

    localparam logic [15:0] B_BASE = full_csum(0);

    function automatic logic [7:0] pay_b(input int seed, input int k);
        return 8'(seed * 29 + k * 7 + (k >> 4));
    endfunction

    typedef struct {
        logic [7:0] d;
        logic       sof;
        logic       eof;
        int         idx;
        string      req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [15:0] pay_len_i = '0;
    logic [7:0]  pay_data_i = '0;
    logic        pay_phase_o, sof_o, eof_o, src_rdy_o;
    logic [7:0]  data_o;

    exp_t exp_q[$];
    int   len_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    int   frames_seen = 0;
    int   cur_seed = 0;
    int   pos = 0;
    int   ph_cnt = 0;
    logic ph_prev = 1'b0;

    always #2 clk = ~clk;

    udp_frame_tx #(
        .DST_MAC   (B_DMAC),
        .SRC_MAC   (B_SMAC),
        .SRC_IP    (B_SIP),
        .DST_IP    (B_DIP),
        .SRC_PORT  (B_SPORT),
        .DST_PORT  (B_DPORT),
        .CSUM_BASE (B_BASE)
    ) u_udp_frame_tx (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .pay_len_i   (pay_len_i),
        .pay_data_i  (pay_data_i),
        .pay_phase_o (pay_phase_o),
        .data_o      (data_o),
        .sof_o       (sof_o),
        .eof_o       (eof_o),
        .src_rdy_o   (src_rdy_o)
    );

    task automatic check(input logic ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: pushes the expected frame into the scoreboard
    task automatic push_frame(input int len, input int seed);
        logic [7:0] h [42];
        logic [15:0] tl, ul, cs;
        exp_t it;
        tl = 16'(28 + len);
        ul = 16'(8 + len);
        cs = full_csum(len);
        for (int i = 0; i < 6; i++) h[i] = B_DMAC[8*(5-i) +: 8];
        for (int i = 0; i < 6; i++) h[6+i] = B_SMAC[8*(5-i) +: 8];
        h[12] = 8'h08; h[13] = 8'h00; h[14] = 8'h45; h[15] = 8'h00;
        h[16] = tl[15:8]; h[17] = tl[7:0];
        h[18] = 8'h00; h[19] = 8'h00; h[20] = 8'h40; h[21] = 8'h00;
        h[22] = 8'h40; h[23] = 8'h11; h[24] = cs[15:8]; h[25] = cs[7:0];
        for (int i = 0; i < 4; i++) h[26+i] = B_SIP[8*(3-i) +: 8];
        for (int i = 0; i < 4; i++) h[30+i] = B_DIP[8*(3-i) +: 8];
        h[34] = B_SPORT[15:8]; h[35] = B_SPORT[7:0];
        h[36] = B_DPORT[15:8]; h[37] = B_DPORT[7:0];
        h[38] = ul[15:8]; h[39] = ul[7:0]; h[40] = 8'h00; h[41] = 8'h00;
        for (int k = 0; k < 42 + len; k++) begin
            it.idx = k;
            it.sof = (k == 0);
            it.eof = (k == 41 + len);
            it.d   = (k < 42) ? h[k] : pay_b(seed, k - 42);
            if (k == 0) it.req = "R1";
            else if (k == 16 || k == 17 || k == 38 || k == 39) it.req = "R3";
            else if (k == 24 || k == 25) it.req = "R4";
            else if (it.eof) it.req = (len == 0) ? "R8" : "R6";
            else if (k >= 42) it.req = "R7";
            else it.req = "R2";
            exp_q.push_back(it);
        end
        len_q.push_back(len);
    endtask

    task automatic pulse_start(input int len);
        @(negedge clk);
        start_i   = 1'b1;
        pay_len_i = 16'(len);
        @(negedge clk);
        start_i   = 1'b0;
        pay_len_i = 16'hDEAD;  // R1: must not be sampled outside the start cycle
    endtask

    task automatic wait_frame(input int target);
        while (frames_seen < target) @(negedge clk);
    endtask

    task automatic send_frame(input int len, input int seed);
        int target;
        target = frames_seen + 1;
        push_frame(len, seed);
        cur_seed = seed;
        pulse_start(len);
        wait_frame(target);
    endtask

    // Payload source: drives byte k in the (k+1)-th cycle after phase rises
    initial begin
        int pcnt;
        pcnt = 0;
        forever begin
            @(negedge clk);
            if (pay_phase_o) begin
                if (pcnt > 0) pay_data_i = pay_b(cur_seed, pcnt - 1);
                pcnt++;
            end else begin
                pcnt = 0;
                pay_data_i = 8'hA5;
            end
        end
    end

    // Monitor: pops expected bytes and compares
    always @(negedge clk) begin
        if (rst) begin
            pos = 0;
            ph_cnt = 0;
            ph_prev = 1'b0;
        end else begin
            if (pay_phase_o && !ph_prev)
                check(pos == 40, "R7", "phase rise position", pos, 40);
            if (pay_phase_o) ph_cnt++;
            ph_prev = pay_phase_o;
            if (src_rdy_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected byte", int'(data_o), 0);
                end else begin
                    exp_t it;
                    it = exp_q.pop_front();
                    check(data_o == it.d && sof_o == it.sof && eof_o == it.eof, it.req,
                          $sformatf("byte %0d {data,sof,eof}", it.idx),
                          int'({data_o, sof_o, eof_o}), int'({it.d, it.sof, it.eof}));
                end
                if (eof_o) begin
                    if (len_q.size() != 0) begin
                        int l;
                        l = len_q.pop_front();
                        check(pos + 1 == 42 + l, "R5", "contiguous frame length", pos + 1, 42 + l);
                        check(ph_cnt == ((l == 0) ? 0 : l + 1), (l == 0) ? "R8" : "R7",
                              "phase high cycles", ph_cnt, (l == 0) ? 0 : l + 1);
                    end
                    pos = 0;
                    ph_cnt = 0;
                    frames_seen++;
                end else begin
                    pos++;
                end
            end else if (pos != 0) begin
                check(1'b0, "R5", "gap inside frame", pos, 0);
                pos = 0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R5", "watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int target;
        repeat (3) @(negedge clk);
        check({src_rdy_o, sof_o, eof_o, pay_phase_o} == 4'b0, "R10", "flags in reset",
              int'({src_rdy_o, sof_o, eof_o, pay_phase_o}), 0);
        rst = 1'b0;
        @(negedge clk);
        check({src_rdy_o, sof_o, eof_o, pay_phase_o} == 4'b0, "R10", "idle after reset",
              int'({src_rdy_o, sof_o, eof_o, pay_phase_o}), 0);

        send_frame(0, 1);    // R8 header only
        send_frame(1, 2);
        send_frame(2, 3);
        send_frame(17, 4);
        send_frame(64, 5);
        send_frame(300, 6);
        send_frame(1400, 7);
        send_frame(3, 8);    // follows immediately after the previous end

        // R9: second start in mid-frame is ignored
        target = frames_seen + 1;
        push_frame(5, 9);
        cur_seed = 9;
        pulse_start(5);
        repeat (10) @(negedge clk);
        pulse_start(33);
        wait_frame(target);
        repeat (80) @(negedge clk);
        check(frames_seen == target && exp_q.size() == 0, "R9", "frames after busy start",
              frames_seen, target);

        // R10: reset during header aborts the frame
        push_frame(20, 10);
        cur_seed = 10;
        pulse_start(20);
        repeat (15) @(negedge clk);
        #1 rst = 1'b1;
        exp_q.delete();
        len_q.delete();
        repeat (2) @(negedge clk);
        check({src_rdy_o, sof_o, eof_o, pay_phase_o} == 4'b0, "R10", "flags after mid-frame reset",
              int'({src_rdy_o, sof_o, eof_o, pay_phase_o}), 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        check(src_rdy_o == 1'b0, "R10", "stays idle after reset", int'(src_rdy_o), 0);

        send_frame(9, 11);
        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R5", "scoreboard drained", exp_q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule